// File: doc/BRIEF.md
# Accumulator Status Flag Register

This block holds the 8-bit program status word of a small accumulator-based CPU and computes its flags. Each cycle the ALU reports an operation class together with its two operands and a carry/borrow input. The block works out carry, half-carry and signed overflow from those values and stores them for the next cycle. The overflow rule depends on the operation: sign change for add and subtract, a product wider than one byte for multiply, and a zero divisor for divide.

Software can load the whole word at once or change any single writable bit. The parity bit is not stored. It always shows the XOR of the accumulator presented on the input. The two bank-select bits set where the working register bank starts. The block outputs both that base and the full 5-bit address of a register picked by a 3-bit index.

Top module: `psw_status_reg`

## Requirements
- R1: After reset every stored bit is 0. The word is laid out MSB to LSB as carry (bit 7), half-carry (6), user flag A (5), bank select high (4), bank select low (3), overflow (2), user flag B (1), parity (0).
- R2: ADD (op code 1) and ADDC (op code 2) add the operands, with ADDC also adding carry_in_i and ADD ignoring it. On the next cycle, carry = carry out of bit 7, half-carry = carry out of bit 3, and overflow = signed two's-complement overflow.
- R3: SUBB (op code 3) computes a - b - carry_in_i. Carry = borrow out of bit 7, half-carry = borrow into bit 3 from the upper nibble, and overflow = signed overflow.
- R4: MUL (op code 4) clears carry and half-carry and sets overflow exactly when the 16-bit product of the operands exceeds 255.
- R5: DIV (op code 5) clears carry and half-carry and sets overflow exactly when the divisor (operand b) is zero.
- R6: Any other arithmetic (op code 6) clears carry and half-carry and leaves overflow unchanged. Op code 0 (no operation) and op code 7 leave all three unchanged.
- R7: Parity (bit 0) is combinational and equals the XOR of acc_i. Software writes to bit 0 are ignored.
- R8: A byte write loads bits 7..1 from sw_byte_data_i on the next cycle. A bit write sets bit sw_bit_sel_i to sw_bit_val_i, with sel 0 ignored. If both happen in one cycle, the bit write is applied on top of the byte write.
- R9: When an arithmetic operation updates a flag in the same cycle as a software write to that flag, the arithmetic value is stored. Flags the operation does not update take the software value.
- R10: User flags A and B and the bank-select bits change only through software writes.
- R11: bank_base_o = {bank select, 3'b000} and reg_addr_o = {bank select, reg_idx_i}. Both follow the stored bank select bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alu_op_i | input | 3 | Operation class: 0 none, 1 ADD, 2 ADDC, 3 SUBB, 4 MUL, 5 DIV, 6 other arithmetic |
| op_a_i | input | 8 | First operand (dividend for DIV) |
| op_b_i | input | 8 | Second operand (divisor for DIV) |
| carry_in_i | input | 1 | Carry for ADDC, borrow for SUBB |
| acc_i | input | 8 | Current accumulator value, for parity |
| sw_byte_we_i | input | 1 | Whole-word software write strobe |
| sw_byte_data_i | input | 8 | Whole-word write data |
| sw_bit_we_i | input | 1 | Single-bit software write strobe |
| sw_bit_sel_i | input | 3 | Bit position for the single-bit write |
| sw_bit_val_i | input | 1 | Value for the single-bit write |
| reg_idx_i | input | 3 | Register index within the bank |
| psw_o | output | 8 | Status word, parity live in bit 0 |
| bank_base_o | output | 5 | Base address of the selected bank |
| reg_addr_o | output | 5 | Address of the indexed register in the selected bank |

## Verification
The bench targets the sign-overflow edges: 0x7F+1 and 0x80-1 must raise overflow, while 0xFF+1 must raise carry and half-carry without it. A design that looked only at the carry out of bit 7 would get these wrong. It also probes the multiply edge (255 against 256) and a zero divisor. Other cases cover ADD with a live carry input, which catches a design that feeds the carry into plain addition, and the "other arithmetic" class, where a design that clears overflow too would lose a set flag. Collisions between software writes and arithmetic updates, and parity writes, show whether the wrong source wins or whether bit 0 became writable.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 3'd0,
    OP_ADD   = 3'd1,
    OP_ADDC  = 3'd2,
    OP_SUBB  = 3'd3,
    OP_MUL   = 3'd4,
    OP_DIV   = 3'd5,
    OP_OTHER = 3'd6,
    OP_RSVD  = 3'd7
  } alu_op_e;

  localparam int unsigned POS_CY  = 7;
  localparam int unsigned POS_AC  = 6;
  localparam int unsigned POS_UA  = 5;
  localparam int unsigned POS_RS1 = 4;
  localparam int unsigned POS_RS0 = 3;
  localparam int unsigned POS_OV  = 2;
  localparam int unsigned POS_UB  = 1;
  localparam int unsigned POS_PAR = 0;
endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/psw_flag_calc.sv
module psw_flag_calc
  import psw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic              upd_cyac_o,
  output logic              upd_ov_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              ov_o
);
  localparam int unsigned HALF = DATA_W / 2;
  localparam int unsigned PW   = 2 * DATA_W;

  logic [DATA_W:0]   add_full, sub_full;
  logic [HALF:0]     add_nib, sub_nib;
  logic [PW-1:0]     prod;
  logic              cin_eff;
  logic              add_ov, sub_ov;

  always_comb begin
    cin_eff  = (op_i == OP_ADDC) ? cin_i : 1'b0;
    add_full = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_eff};
    add_nib  = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]} + {{HALF{1'b0}}, cin_eff};
    sub_full = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_i};
    sub_nib  = {1'b0, a_i[HALF-1:0]} - {1'b0, b_i[HALF-1:0]} - {{HALF{1'b0}}, cin_i};
    prod     = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};
    add_ov   = (a_i[DATA_W-1] == b_i[DATA_W-1]) && (add_full[DATA_W-1] != a_i[DATA_W-1]);
    sub_ov   = (a_i[DATA_W-1] != b_i[DATA_W-1]) && (sub_full[DATA_W-1] != a_i[DATA_W-1]);
  end

  always_comb begin
    upd_cyac_o = 1'b0;
    upd_ov_o   = 1'b0;
    cy_o       = 1'b0;
    ac_o       = 1'b0;
    ov_o       = 1'b0;
    unique case (op_i)
      OP_ADD, OP_ADDC: begin
        upd_cyac_o = 1'b1;
        upd_ov_o   = 1'b1;
        cy_o       = add_full[DATA_W];
        ac_o       = add_nib[HALF];
        ov_o       = add_ov;
      end
      OP_SUBB: begin
        upd_cyac_o = 1'b1;
        upd_ov_o   = 1'b1;
        cy_o       = sub_full[DATA_W];
        ac_o       = sub_nib[HALF];
        ov_o       = sub_ov;
      end
      OP_MUL: begin
        upd_cyac_o = 1'b1;
        upd_ov_o   = 1'b1;
        ov_o       = |prod[PW-1:DATA_W];
      end
      OP_DIV: begin
        upd_cyac_o = 1'b1;
        upd_ov_o   = 1'b1;
        ov_o       = (b_i == '0);
      end
      OP_OTHER: begin
        upd_cyac_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/psw_bank_map.sv
module psw_bank_map #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned IDX_W = 3
) (
  input  logic [SEL_W-1:0]       bank_sel_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [SEL_W+IDX_W-1:0] base_o,
  output logic [SEL_W+IDX_W-1:0] addr_o
);
  always_comb begin
    base_o = {bank_sel_i, {IDX_W{1'b0}}};
    addr_o = {bank_sel_i, idx_i};
  end
endmodule

// File: rtl/psw_status_reg.sv
module psw_status_reg
  import psw_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             alu_op_i,
  input  logic [DATA_W-1:0]      op_a_i,
  input  logic [DATA_W-1:0]      op_b_i,
  input  logic                   carry_in_i,
  input  logic [DATA_W-1:0]      acc_i,
  input  logic                   sw_byte_we_i,
  input  logic [7:0]             sw_byte_data_i,
  input  logic                   sw_bit_we_i,
  input  logic [2:0]             sw_bit_sel_i,
  input  logic                   sw_bit_val_i,
  input  logic [IDX_W-1:0]       reg_idx_i,
  output logic [7:0]             psw_o,
  output logic [SEL_W+IDX_W-1:0] bank_base_o,
  output logic [SEL_W+IDX_W-1:0] reg_addr_o
);
  localparam int unsigned AW = SEL_W + IDX_W;

  logic       rst_sync_n;
  logic [7:1] stat_q, stat_d;
  logic       stat_en;
  logic       upd_cyac, upd_ov, cy_n, ac_n, ov_n;
  logic       unused_par_bit;
  alu_op_e    op;

  assign op             = alu_op_e'(alu_op_i);
  assign unused_par_bit = sw_byte_data_i[POS_PAR];

  psw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psw_flag_calc #(.DATA_W(DATA_W)) u_calc (
    .op_i       (op),
    .a_i        (op_a_i),
    .b_i        (op_b_i),
    .cin_i      (carry_in_i),
    .upd_cyac_o (upd_cyac),
    .upd_ov_o   (upd_ov),
    .cy_o       (cy_n),
    .ac_o       (ac_n),
    .ov_o       (ov_n)
  );

  // Next state: byte write, then bit write, then arithmetic (highest priority).
  always_comb begin
    stat_d = stat_q;
    if (sw_byte_we_i) stat_d = sw_byte_data_i[7:1];
    if (sw_bit_we_i && (sw_bit_sel_i != 3'(POS_PAR))) stat_d[sw_bit_sel_i] = sw_bit_val_i;
    if (upd_cyac) begin
      stat_d[POS_CY] = cy_n;
      stat_d[POS_AC] = ac_n;
    end
    if (upd_ov) stat_d[POS_OV] = ov_n;
    stat_en = sw_byte_we_i | sw_bit_we_i | upd_cyac | upd_ov;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign psw_o = {stat_q, ^acc_i};

  psw_bank_map #(.SEL_W(SEL_W), .IDX_W(IDX_W)) u_bank (
    .bank_sel_i (stat_q[POS_RS1:POS_RS0]),
    .idx_i      (reg_idx_i),
    .base_o     (bank_base_o),
    .addr_o     (reg_addr_o)
  );

  // R4: multiply always leaves carry and half-carry clear
  assert_mul_clears_cy_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == OP_MUL) |=> (psw_o[POS_CY] == 1'b0 && psw_o[POS_AC] == 1'b0));

  // R5: divide by zero raises overflow
  assert_div_zero_ov_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == OP_DIV && op_b_i == '0) |=> psw_o[POS_OV]);

  // R6: other arithmetic without a software write keeps overflow
  assert_other_keeps_ov_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == OP_OTHER && !sw_byte_we_i && !sw_bit_we_i) |=> $stable(psw_o[POS_OV]));

  // R10: user flag A changes only when software writes it
  assert_user_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sw_byte_we_i && !(sw_bit_we_i && sw_bit_sel_i == 3'(POS_UA))) |=> $stable(psw_o[POS_UA]));

  // R6: idle cycle keeps the whole stored word
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == OP_NONE && !sw_byte_we_i && !sw_bit_we_i) |=> $stable(psw_o[7:1]));

  // R11: bank part of the register address tracks the status word
  assert_bank_addr_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |-> (reg_addr_o[AW-1:IDX_W] == psw_o[POS_RS1:POS_RS0]));
endmodule

// File: tb/psw_status_reg_tb_top.sv
module psw_status_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] alu_op;
  logic [7:0] op_a, op_b, acc, byte_data;
  logic       cin, byte_we, bit_we, bit_val;
  logic [2:0] bit_sel, reg_idx;
  logic [7:0] psw;
  logic [4:0] bank_base, reg_addr;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:1] model;
  logic [17:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  psw_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .alu_op_i(alu_op), .op_a_i(op_a), .op_b_i(op_b),
    .carry_in_i(cin), .acc_i(acc), .sw_byte_we_i(byte_we), .sw_byte_data_i(byte_data),
    .sw_bit_we_i(bit_we), .sw_bit_sel_i(bit_sel), .sw_bit_val_i(bit_val),
    .reg_idx_i(reg_idx), .psw_o(psw), .bank_base_o(bank_base), .reg_addr_o(reg_addr)
  );

  function automatic int sgn(input logic [7:0] v);
    return (v > 127) ? int'(v) - 256 : int'(v);
  endfunction

  task automatic compare(input string tag, input logic [17:0] exp);
    logic [17:0] got;
    got = {psw, bank_base, reg_addr};
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: psw/base/addr got %h/%h/%h expected %h/%h/%h",
               tag, psw, bank_base, reg_addr, exp[17:10], exp[9:5], exp[4:0]);
    end
  endtask

  // Driver: drive one cycle of stimulus and push the expected post-edge view.
  task automatic step(input string tag, input logic [2:0] op, input logic [7:0] a,
                      input logic [7:0] b, input logic c, input logic [7:0] ac,
                      input logic bw, input logic [7:0] bd, input logic tw,
                      input logic [2:0] ts, input logic tv, input logic [2:0] idx);
    int r, nib;
    @(negedge clk);
    alu_op = op; op_a = a; op_b = b; cin = c; acc = ac; byte_we = bw; byte_data = bd;
    bit_we = tw; bit_sel = ts; bit_val = tv; reg_idx = idx;
    if (bw) model = bd[7:1];
    if (tw && ts != 0) model[ts] = tv;
    case (op)
      3'd1, 3'd2: begin
        r   = int'(a) + int'(b) + ((op == 3'd2) ? int'(c) : 0);
        nib = int'(a % 16) + int'(b % 16) + ((op == 3'd2) ? int'(c) : 0);
        model[7] = (r > 255); model[6] = (nib > 15);
        r = sgn(a) + sgn(b) + ((op == 3'd2) ? int'(c) : 0);
        model[2] = (r > 127) || (r < -128);
      end
      3'd3: begin
        r = int'(a) - int'(b) - int'(c); nib = int'(a % 16) - int'(b % 16) - int'(c);
        model[7] = (r < 0); model[6] = (nib < 0);
        r = sgn(a) - sgn(b) - int'(c);
        model[2] = (r > 127) || (r < -128);
      end
      3'd4: begin model[7] = 0; model[6] = 0; model[2] = (int'(a) * int'(b) > 255); end
      3'd5: begin model[7] = 0; model[6] = 0; model[2] = (b == 0); end
      3'd6: begin model[7] = 0; model[6] = 0; end
      default: ;
    endcase
    exp_q.push_back({model, ^ac, model[4:3], 3'b000, model[4:3], idx});
    tag_q.push_back(tag);
  endtask

  // Monitor: after each edge, pop and compare.
  initial begin
    forever begin
      @(posedge clk); #5;
      if (exp_q.size() > 0) compare(tag_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; alu_op = 0; op_a = 0; op_b = 0; cin = 0; acc = 0; byte_we = 0;
    byte_data = 0; bit_we = 0; bit_sel = 0; bit_val = 0; reg_idx = 3'd5;
    model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 reset state", {8'h00, 5'h00, 5'h05});

    // R2 add family
    step("R2 ADD 7F+01 signed ovf", 1, 8'h7F, 8'h01, 0, 8'h80, 0, 0, 0, 0, 0, 0);
    step("R2 ADD FF+01 carry",      1, 8'hFF, 8'h01, 0, 8'h00, 0, 0, 0, 0, 0, 0);
    step("R2 ADD ignores carry_in", 1, 8'hFF, 8'h00, 1, 8'h03, 0, 0, 0, 0, 0, 0);
    step("R2 ADDC FF+00+1",         2, 8'hFF, 8'h00, 1, 8'h07, 0, 0, 0, 0, 0, 0);
    step("R2 ADDC 0E+01+1 nibble",  2, 8'h0E, 8'h01, 1, 8'h01, 0, 0, 0, 0, 0, 0);
    // R3 subtract with borrow
    step("R3 SUBB 00-01 borrow",    3, 8'h00, 8'h01, 0, 8'h00, 0, 0, 0, 0, 0, 1);
    step("R3 SUBB 80-01 signed",    3, 8'h80, 8'h01, 0, 8'h00, 0, 0, 0, 0, 0, 1);
    step("R3 SUBB 10-0F-1 nibble",  3, 8'h10, 8'h0F, 1, 8'h00, 0, 0, 0, 0, 0, 1);
    step("R3 SUBB 05-02 clean",     3, 8'h05, 8'h02, 0, 8'h00, 0, 0, 0, 0, 0, 1);
    // R4 multiply
    step("R4 MUL 10*10=256",        4, 8'h10, 8'h10, 0, 8'h00, 0, 0, 0, 0, 0, 2);
    step("R4 MUL 0F*11=255",        4, 8'h0F, 8'h11, 0, 8'h00, 0, 0, 0, 0, 0, 2);
    // R5 divide
    step("R5 DIV by zero",          5, 8'h40, 8'h00, 0, 8'h00, 0, 0, 0, 0, 0, 2);
    step("R5 DIV by three",         5, 8'h40, 8'h03, 0, 8'h00, 0, 0, 0, 0, 0, 2);
    // R6 other arithmetic / none
    step("R6 set ovf via ADD",      1, 8'h7F, 8'h7F, 0, 8'h00, 0, 0, 0, 0, 0, 3);
    step("R6 other keeps ovf",      6, 8'hFF, 8'hFF, 1, 8'h00, 0, 0, 0, 0, 0, 3);
    step("R6 none keeps all",       0, 8'hFF, 8'hFF, 1, 8'h00, 0, 0, 0, 0, 0, 3);
    step("R6 code 7 keeps all",     7, 8'hFF, 8'h00, 1, 8'h00, 0, 0, 0, 0, 0, 3);
    // R8 / R7 software writes and parity
    step("R8 byte write FF",        0, 0, 0, 0, 8'h01, 1, 8'hFF, 0, 0, 0, 4);
    step("R7 bit write to parity",  0, 0, 0, 0, 8'h00, 0, 0, 1, 0, 1, 4);
    step("R7 parity odd acc",       0, 0, 0, 0, 8'hB5, 0, 0, 0, 0, 0, 4);
    step("R8 bit write clear flag A", 0, 0, 0, 0, 8'h00, 0, 0, 1, 5, 0, 4);
    step("R8 byte+bit same cycle",  0, 0, 0, 0, 8'h00, 1, 8'h00, 1, 1, 1, 4);
    // R9 collisions
    step("R9 ADD beats byte write", 1, 8'hFF, 8'h01, 0, 8'h00, 1, 8'h20, 0, 0, 0, 4);
    step("R9 OTHER lets ovf write", 6, 8'h00, 8'h00, 0, 8'h00, 0, 0, 1, 2, 1, 4);
    step("R9 SUBB beats CY clear",  3, 8'h00, 8'h01, 0, 8'h00, 0, 0, 1, 7, 0, 4);
    // R10 user flags/bank hold across arithmetic
    step("R10 MUL keeps user flags",4, 8'hFF, 8'hFF, 0, 8'h00, 0, 0, 0, 0, 0, 6);
    // R11 bank sweep
    for (int k = 0; k < 4; k++) begin
      step("R11 bank select write", 0, 0, 0, 0, 8'h00, 1, {3'b000, 2'(k), 3'b000}, 0, 0, 0, 3'(k + 3));
    end
    step("R11 bank bit write RS1",  0, 0, 0, 0, 8'h00, 0, 0, 1, 4, 0, 7);
    step("R10 hold after idle",     0, 0, 0, 0, 8'h6A, 0, 0, 0, 0, 0, 0);

    @(negedge clk);
    alu_op = 0; byte_we = 0; bit_we = 0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule